// File: doc/BRIEF.md
# Two-Stage Switch-Matrix Connection Register Bank

This block stores the connection map for a switch matrix with 33 inputs and 17 outputs. For each output it keeps two registers: a staging copy, which host writes fill, and an active copy, which drives the matrix. The active copy of each output supplies a 6-bit input number and an enable bit. A host can fill the staging copies one output at a time and then move all of them into the active copies in one cycle. It can also write one output's active copy directly, address every output at once through a broadcast code, and read any output's active copy back.

The control port is a parallel interface. It has a 5-bit output address and a 7-bit data word. Bit 6 of the word is the enable and bits 5:0 are the input number. The port also has active-low strobes for select, write, read, commit and clear. All strobes are sampled on the rising edge of `clk`, and each one takes effect at that edge. The bidirectional bus is split into `data_in`, `data_out` and an output-enable `data_oe`. Readback is registered, so the data appears one cycle after the read is sampled.

Top module: `xpt_cfg_bank`

## Requirements
- R1: While `rst_n` is low, all staging and active registers are zero, and `data_out` and `data_oe` are zero.
- R2: An edge where `clr_n` is low clears every active enable bit (`out_en` becomes all zeros). The active input numbers and all staging registers keep their values, and every other strobe sampled at that edge is ignored.
- R3: An edge where `cs_n` is high (and `clr_n` is high) changes no register, and `data_oe` is low after it.
- R4: A staged write (`cs_n`=0, `we_n`=0, `upd_n`=1) loads `data_in` into the staging register of output `addr` only. `out_sel` and `out_en` do not change.
- R5: A read (`cs_n`=0, `we_n`=1, `re_n`=0, `upd_n`=1) sets `data_oe` high after the edge, with `data_out` = {enable, input number} of output `addr`'s active register. After any other edge, `data_oe` and `data_out` are zero.
- R6: A commit (`cs_n`=0, `we_n`=1, `re_n`=1, `upd_n`=0) copies all 17 staging registers into the active registers in one edge.
- R7: A direct write (`cs_n`=0, `we_n`=0, `upd_n`=0) loads `data_in` into both the staging and the active register of output `addr`. All other outputs are unchanged.
- R8: Address 17 (5'b10001) is the broadcast code. A staged or direct write to it loads every output's staging register, and for a direct write every active register too, with the same word. A read of address 17 returns zero with `data_oe` high.
- R9: A write with `addr` in 18..31, or with `data_in[5:0]` in 33..63, changes nothing. A read of `addr` 18..31 returns zero with `data_oe` high.
- R10: The combination `cs_n`=0, `we_n`=1, `re_n`=0, `upd_n`=0 is a no-op: no register changes and `data_oe` is low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Active-low select; when high, all other strobes are ignored |
| we_n | input | 1 | Active-low write strobe |
| re_n | input | 1 | Active-low read strobe |
| upd_n | input | 1 | Active-low commit strobe (direct write when combined with write) |
| clr_n | input | 1 | Active-low clear of all active enable bits; overrides all other strobes |
| addr | input | 5 | Output address: 0..16, broadcast 17, reserved 18..31 |
| data_in | input | 7 | Write word: bit 6 enable, bits 5:0 input number |
| data_out | output | 7 | Registered readback word |
| data_oe | output | 1 | High in the cycle after a read; marks `data_out` as driven |
| out_sel | output | 102 | Active input number per output; output k uses bits 6k+5:6k |
| out_en | output | 17 | Active enable per output; bit k belongs to output k |

## Verification
The staging registers are hidden from the ports. A corrupted staging value shows up only at the next commit, as a wrong `out_sel` or `out_en` slice one edge later. The bench therefore follows every group of staged writes with a commit, and reads every output back. A fault in an active register, such as a clear that also wipes input numbers, or a write that lands on the wrong output, is visible on `out_sel`/`out_en` right after the edge that caused it. A fault in the readback path shows on `data_out` one cycle after the read. Every operation is followed by a comparison of all 17 outputs against a bench model, so a fault is caught within one cycle of becoming visible.

// File: rtl/xpt_pkg.sv
`timescale 1ns/1ps
package xpt_pkg;
  localparam int N_OUT  = 17;
  localparam int N_IN   = 33;
  localparam int SEL_W  = 6;
  localparam int ADDR_W = 5;
  localparam int DATA_W = SEL_W + 1;
  localparam logic [ADDR_W-1:0] BCAST_A = ADDR_W'(N_OUT);
  localparam logic [SEL_W-1:0]  SEL_LIM = SEL_W'(N_IN);

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } xcfg_t;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_CLR,
    CMD_STAGE,
    CMD_THRU,
    CMD_READ,
    CMD_COMMIT
  } xcmd_t;
endpackage

// File: rtl/xpt_cmd_dec.sv
`timescale 1ns/1ps
module xpt_cmd_dec
  import xpt_pkg::*;
(
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              re_n,
  input  logic              upd_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr,
  input  xcfg_t             wdata,
  output logic              clr_act,
  output logic              upd_all,
  output logic              rd_req,
  output logic [N_OUT-1:0]  stage_we,
  output logic [N_OUT-1:0]  act_we
);
  xcmd_t cmd;
  logic  wr_ok;

  // Strobe priority: clear, then select, then write, then read/commit.
  always_comb begin
    cmd = CMD_NONE;
    if (!clr_n) begin
      cmd = CMD_CLR;
    end else if (!cs_n) begin
      if (!we_n)                 cmd = upd_n ? CMD_STAGE : CMD_THRU;
      else if (!re_n && upd_n)   cmd = CMD_READ;
      else if (re_n && !upd_n)   cmd = CMD_COMMIT;
    end
  end

  assign wr_ok   = (addr <= BCAST_A) && (wdata.sel < SEL_LIM);
  assign clr_act = (cmd == CMD_CLR);
  assign upd_all = (cmd == CMD_COMMIT);
  assign rd_req  = (cmd == CMD_READ);

  for (genvar o = 0; o < N_OUT; o++) begin : g_hit
    logic hit;
    assign hit         = wr_ok && ((addr == ADDR_W'(o)) || (addr == BCAST_A));
    assign stage_we[o] = hit && ((cmd == CMD_STAGE) || (cmd == CMD_THRU));
    assign act_we[o]   = hit && (cmd == CMD_THRU);
  end
endmodule

// File: rtl/xpt_out_cell.sv
`timescale 1ns/1ps
module xpt_out_cell
  import xpt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stage_we,
  input  logic  act_we,
  input  logic  upd_all,
  input  logic  clr_act,
  input  xcfg_t wdata,
  output xcfg_t act_q
);
  xcfg_t stage_q, stage_d, act_d;
  logic  stage_en, act_en;

  assign stage_en = stage_we;
  assign act_en   = clr_act | act_we | upd_all;

  always_comb begin
    stage_d = wdata;
    act_d   = act_q;
    if (clr_act)      act_d.en = 1'b0;
    else if (act_we)  act_d    = wdata;
    else if (upd_all) act_d    = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (act_en)   act_q   <= act_d;
    end
  end
endmodule

// File: rtl/xpt_rd_reg.sv
`timescale 1ns/1ps
module xpt_rd_reg
  import xpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  input  xcfg_t [N_OUT-1:0] act_all,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (rd_req) begin
      for (int o = 0; o < N_OUT; o++) begin
        if (addr == ADDR_W'(o)) rd_d = act_all[o];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      data_oe  <= 1'b0;
    end else begin
      data_out <= rd_d;
      data_oe  <= rd_req;
    end
  end
endmodule

// File: rtl/xpt_cfg_bank.sv
`timescale 1ns/1ps
module xpt_cfg_bank
  import xpt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    we_n,
  input  logic                    re_n,
  input  logic                    upd_n,
  input  logic                    clr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       data_in,
  output logic [DATA_W-1:0]       data_out,
  output logic                    data_oe,
  output logic [N_OUT*SEL_W-1:0]  out_sel,
  output logic [N_OUT-1:0]        out_en
);
  xcfg_t              wdata;
  xcfg_t [N_OUT-1:0]  act_all;
  logic               clr_act, upd_all, rd_req;
  logic [N_OUT-1:0]   stage_we, act_we;

  assign wdata = xcfg_t'(data_in);

  xpt_cmd_dec u_dec (
    .cs_n     (cs_n),
    .we_n     (we_n),
    .re_n     (re_n),
    .upd_n    (upd_n),
    .clr_n    (clr_n),
    .addr     (addr),
    .wdata    (wdata),
    .clr_act  (clr_act),
    .upd_all  (upd_all),
    .rd_req   (rd_req),
    .stage_we (stage_we),
    .act_we   (act_we)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    xpt_out_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .stage_we (stage_we[o]),
      .act_we   (act_we[o]),
      .upd_all  (upd_all),
      .clr_act  (clr_act),
      .wdata    (wdata),
      .act_q    (act_all[o])
    );
    assign out_sel[o*SEL_W +: SEL_W] = act_all[o].sel;
    assign out_en[o]                 = act_all[o].en;
  end

  xpt_rd_reg u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .addr     (addr),
    .act_all  (act_all),
    .data_out (data_out),
    .data_oe  (data_oe)
  );
endmodule

// File: rtl/xpt_cfg_bank_chk.sv
`timescale 1ns/1ps
module xpt_cfg_bank_chk
  import xpt_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   we_n,
  input logic                   re_n,
  input logic                   upd_n,
  input logic                   clr_n,
  input logic [ADDR_W-1:0]      addr,
  input logic [DATA_W-1:0]      data_in,
  input logic [DATA_W-1:0]      data_out,
  input logic                   data_oe,
  input logic [N_OUT*SEL_W-1:0] out_sel,
  input logic [N_OUT-1:0]       out_en
);
  logic is_rd, is_stage, is_wr, is_noop;
  assign is_rd    = clr_n && !cs_n && we_n && !re_n && upd_n;
  assign is_stage = clr_n && !cs_n && !we_n && upd_n;
  assign is_wr    = clr_n && !cs_n && !we_n;
  assign is_noop  = clr_n && !cs_n && we_n && !re_n && !upd_n;

  AST_CLR_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (out_en == '0)); // R2
  AST_CLR_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> $stable(out_sel)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && cs_n) |=> ($stable(out_sel) && $stable(out_en) && !data_oe)); // R3
  AST_STAGE_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    is_stage |=> ($stable(out_sel) && $stable(out_en))); // R4
  AST_READ_OE: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> data_oe); // R5
  AST_OE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> $past(is_rd)); // R5
  AST_BCAST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && addr >= BCAST_A) |=> (data_out == '0)); // R8
  AST_RSVD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && addr > BCAST_A) |=> ($stable(out_sel) && $stable(out_en))); // R9
  AST_NOOP_COMBO: assert property (@(posedge clk) disable iff (!rst_n)
    is_noop |=> ($stable(out_sel) && $stable(out_en) && !data_oe)); // R10
endmodule

bind xpt_cfg_bank xpt_cfg_bank_chk u_chk (.*);

// File: tb/xpt_cfg_bank_tb.sv
`timescale 1ns/1ps
module xpt_cfg_bank_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cs_n, we_n, re_n, upd_n, clr_n;
  logic [4:0]   addr;
  logic [6:0]   data_in;
  logic [6:0]   data_out;
  logic         data_oe;
  logic [101:0] out_sel;
  logic [16:0]  out_en;

  int n_run  = 0;
  int n_fail = 0;

  logic [6:0] m_stage [17];
  logic [6:0] m_act   [17];
  logic [6:0] e_dout;
  logic       e_oe;

  always #4 clk = ~clk;

  xpt_cfg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .re_n(re_n),
    .upd_n(upd_n), .clr_n(clr_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .out_sel(out_sel), .out_en(out_en)
  );

  function automatic logic [101:0] exp_sel();
    logic [101:0] v;
    for (int o = 0; o < 17; o++) v[o*6 +: 6] = m_act[o][5:0];
    return v;
  endfunction

  function automatic logic [16:0] exp_en();
    logic [16:0] v;
    for (int o = 0; o < 17; o++) v[o] = m_act[o][6];
    return v;
  endfunction

  task automatic check(input string tag);
    logic [126:0] act, exp;
    act = {out_en, out_sel, data_oe, data_out};
    exp = {exp_en(), exp_sel(), e_oe, e_dout};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bench model of one sampled edge, written from the requirements.
  task automatic model(input logic cs, we, re, upd, clr,
                       input logic [4:0] a, input logic [6:0] d);
    e_oe = 1'b0;
    e_dout = '0;
    if (!clr) begin
      for (int o = 0; o < 17; o++) m_act[o][6] = 1'b0;
    end else if (!cs) begin
      if (!we) begin
        if (a <= 5'd17 && d[5:0] <= 6'd32) begin
          for (int o = 0; o < 17; o++) begin
            if (a == 5'd17 || a == 5'(o)) begin
              m_stage[o] = d;
              if (!upd) m_act[o] = d;
            end
          end
        end
      end else if (!re && upd) begin
        e_oe = 1'b1;
        if (a < 5'd17) e_dout = m_act[a];
      end else if (re && !upd) begin
        for (int o = 0; o < 17; o++) m_act[o] = m_stage[o];
      end
    end
  endtask

  task automatic op(input logic cs, we, re, upd, clr,
                    input logic [4:0] a, input logic [6:0] d, input string tag);
    cs_n = cs; we_n = we; re_n = re; upd_n = upd; clr_n = clr;
    addr = a; data_in = d;
    @(negedge clk);
    model(cs, we, re, upd, clr, a, d);
    cs_n = 1'b1; we_n = 1'b1; re_n = 1'b1; upd_n = 1'b1; clr_n = 1'b1;
    check(tag);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1; re_n = 1'b1; upd_n = 1'b1; clr_n = 1'b1;
    addr = '0; data_in = '0;
    for (int o = 0; o < 17; o++) begin m_stage[o] = '0; m_act[o] = '0; end
    e_oe = 1'b0; e_dout = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // R4: stage every output; active copy must not move
    for (int o = 0; o < 17; o++)
      op(0, 0, 1, 1, 1, 5'(o), {1'(o % 2), 6'((o * 2) % 33)}, "R4 staged write");
    for (int o = 0; o < 17; o++)
      op(0, 1, 0, 1, 1, 5'(o), 7'h0, "R5 readback before commit");
    op(0, 1, 1, 0, 1, 5'd0, 7'h0, "R6 commit");
    for (int o = 0; o < 17; o++)
      op(0, 1, 0, 1, 1, 5'(o), 7'h0, "R5 readback after commit");

    // R7: direct write, every output against every input number
    for (int o = 0; o < 17; o++)
      for (int i = 0; i < 33; i++)
        op(0, 0, 1, 0, 1, 5'(o), {1'((i + o) % 2), 6'(i)}, "R7 direct write");
    for (int o = 0; o < 17; o++)
      op(0, 1, 0, 1, 1, 5'(o), 7'h0, "R5 readback after direct write");

    op(0, 1, 0, 0, 1, 5'd3, 7'h0, "R10 read+commit combo");
    op(1, 0, 1, 0, 1, 5'd2, 7'h45, "R3 deselected write");
    op(1, 1, 0, 1, 1, 5'd2, 7'h0, "R3 deselected read");
    op(1, 1, 1, 0, 1, 5'd2, 7'h0, "R3 deselected commit");

    // R9: reserved addresses and input numbers
    for (int a = 18; a < 32; a++)
      op(0, 0, 1, 0, 1, 5'(a), 7'h41, "R9 reserved address write");
    for (int d = 33; d < 64; d++)
      op(0, 0, 1, 0, 1, 5'd4, {1'b1, 6'(d)}, "R9 reserved input write");
    for (int a = 18; a < 32; a++)
      op(0, 1, 0, 1, 1, 5'(a), 7'h0, "R9 reserved address read");
    op(0, 1, 1, 0, 1, 5'd0, 7'h0, "R9 commit after reserved staging");

    // R8: broadcast
    op(0, 0, 1, 1, 1, 5'd17, 7'h45, "R8 broadcast staged");
    op(0, 1, 1, 0, 1, 5'd0, 7'h0, "R8 commit of broadcast");
    op(0, 0, 1, 0, 1, 5'd17, 7'h09, "R8 broadcast direct");
    op(0, 1, 0, 1, 1, 5'd17, 7'h0, "R8 broadcast readback zero");
    op(0, 0, 1, 0, 1, 5'd17, 7'h60, "R8 broadcast direct max input");

    // R2: clear overrides a simultaneous direct write; staging survives
    op(0, 0, 1, 1, 1, 5'd5, 7'h47, "R2 setup stage");
    op(0, 0, 1, 0, 0, 5'd1, 7'h4A, "R2 clear with direct write");
    op(1, 1, 1, 1, 0, 5'd0, 7'h0, "R2 clear while deselected");
    op(0, 1, 1, 0, 1, 5'd0, 7'h0, "R2 staging kept after clear");
    for (int o = 0; o < 17; o++)
      op(0, 1, 0, 1, 1, 5'(o), 7'h0, "R2 readback after clear");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule